// File: doc/BRIEF.md
# Latency-Aware Multipath Egress Selector

This block chooses the exit path, and so the egress port, for each outgoing packet headed to one of several destinations, each reachable over a fixed set of candidate paths. It keeps one latency entry per destination and path. An entry is overwritten whenever an acknowledgment for that path comes back carrying a measured end-to-end delay. A packet request names its destination and its layer-4 source and destination ports, and it may ask for a departure timestamp. One cycle later the block returns the chosen path, the egress port number and, if asked, the departure time to be carried as telemetry in the packet.

The path is chosen by a random draw against a programmable preference level. When the draw falls below the level, the block takes the live path with the lowest recorded latency. Otherwise it takes the path indexed by a hash of the flow's port numbers, which keeps a flow on one path. Each path runs a small health state machine with two states, LIVE and FAILED. The transition LIVE to FAILED (expiry) happens when no acknowledgment has arrived for longer than a timeout. The transition FAILED to LIVE (revival) happens on any acknowledgment for that path. FAILED paths are skipped. When every path of a destination has failed, the block uses the plain hash choice.

Top module: `lat_mpath_sel`

## Requirements
- R1: A request sampled at a clock edge produces `sel_valid` high for exactly the following cycle, and `sel_valid` is low whenever no request was sampled at the previous edge, including right after reset.
- R2: The egress port equals destination × N_PATH + chosen path (with two paths: port = 2·dest + path).
- R3: The hash index is the XOR fold of the 32-bit key {sport, dport} in PATH_W-bit chunks, taken modulo N_PATH. With two paths this is the parity of all 32 port bits.
- R4: The block draws r, the low PROB_W bits of a free-running LFSR. If r < `pref_level`, it picks the live path with the lowest latency, with ties going to the lowest path index. Otherwise it picks the hash path if that path is live, or else the lowest-latency live path. `pref_level` = 2^PROB_W therefore always picks the lowest-latency path, and 0 keeps the hash path whenever it is live.
- R5: With `pref_level` at half range and the hash path differing from the lowest-latency path, the lowest-latency path is chosen for roughly half of the requests (between 30% and 70% over 240 requests).
- R6: An acknowledgment replaces the stored latency of its destination and path. A request sampled in the same cycle as the acknowledgment still sees the old value, and a request sampled one cycle later sees the new one.
- R7: A path whose last acknowledgment was sampled at edge e still counts as live for a request sampled at edge e+AGE_LIMIT+1. From edge e+AGE_LIMIT+2 onward it is FAILED and is never chosen while another path of its destination is live.
- R8: An acknowledgment revives a FAILED path. An acknowledgment sampled at the very edge where the path would expire keeps it LIVE, so the acknowledgment wins over the expiry.
- R9: When all paths of the requested destination are FAILED, the hash path is chosen whatever the draw and `pref_level` are.
- R10: A timestamp counter starts at 0 after reset and increases by one each cycle. A request with `req_stamp` set gets `sel_stamped`=1 and `sel_ts` equal to the counter value at its sampling edge, so two stamped requests k cycles apart differ by k. An unstamped request gets `sel_stamped`=0 and `sel_ts`=0.
- R11: Reset sets every path to LIVE with latency 0 and age 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| pref_level | input | PROB_W+1 | Preference level for the lowest-latency path, 0 to 2^PROB_W |
| req_valid | input | 1 | Packet request strobe |
| req_dest | input | DEST_W | Destination index |
| req_sport | input | 16 | Layer-4 source port |
| req_dport | input | 16 | Layer-4 destination port |
| req_stamp | input | 1 | Request a departure timestamp |
| ack_valid | input | 1 | Acknowledgment strobe |
| ack_dest | input | DEST_W | Acknowledged destination |
| ack_path | input | PATH_W | Acknowledged path |
| ack_delay | input | TS_W | Measured delay, unsigned |
| sel_valid | output | 1 | Selection result valid |
| sel_port | output | PORT_W | Chosen egress port |
| sel_path | output | PATH_W | Chosen path index |
| sel_stamped | output | 1 | Timestamp present |
| sel_ts | output | TS_W | Departure timestamp |

## Verification
Two pairs of events can fall in the same cycle. The first pair is a latency update and a selection read of the same destination. The bench drives an acknowledgment that makes the current best path the worst in the same cycle as a request, and it expects the old best path for that request and the other path for the request that follows. The second pair is a revival and an expiry of the same path. The bench acknowledges a path, counts edges exactly up to its expiry edge, acknowledges again at that edge, and expects a request with preference level 0 to keep that path and not fall back to its sibling.

// File: rtl/lat_mpath_pkg.sv
`timescale 1ns/1ps
package lat_mpath_pkg;

    // Health of one candidate path
    typedef enum logic [1:0] {
        PATH_LIVE   = 2'd1,
        PATH_FAILED = 2'd2
    } path_state_e;

    function automatic int idx_width(input int n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

endpackage

// File: rtl/lat_mpath_track.sv
`timescale 1ns/1ps
// Per-path latency entry with an age counter and health state machine.
module lat_mpath_track
    import lat_mpath_pkg::*;
#(
    parameter int LAT_W     = 16,
    parameter int AGE_LIMIT = 200
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             upd,
    input  logic [LAT_W-1:0] upd_lat,
    output logic [LAT_W-1:0] lat,
    output logic             live
);
    localparam int AGE_W = $clog2(AGE_LIMIT + 1);

    path_state_e      st_q, st_d;
    logic [AGE_W-1:0] age_q, age_d;
    logic [LAT_W-1:0] lat_q;
    logic             expired;

    assign expired = (age_q == AGE_W'(AGE_LIMIT));

    // next-state: an acknowledgment always beats expiry
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            PATH_LIVE:   if (!upd && expired) st_d = PATH_FAILED;
            PATH_FAILED: if (upd)             st_d = PATH_LIVE;
            default:                          st_d = PATH_LIVE;
        endcase
    end

    always_comb begin
        if (upd)          age_d = '0;
        else if (expired) age_d = age_q;
        else              age_d = age_q + 1'b1;
    end

    // state register
    always_ff @(posedge clk) begin
        if (rst) begin
            st_q  <= PATH_LIVE;
            age_q <= '0;
            lat_q <= '0;
        end else begin
            st_q  <= st_d;
            age_q <= age_d;
            if (upd) lat_q <= upd_lat;
        end
    end

    // outputs
    always_comb begin
        live = (st_q == PATH_LIVE);
        lat  = lat_q;
    end

endmodule

// File: rtl/lat_mpath_hash.sv
`timescale 1ns/1ps
// XOR fold of {sport, dport} into a path index.
module lat_mpath_hash
    import lat_mpath_pkg::*;
#(
    parameter int N_PATH = 2
) (
    input  logic [15:0]                    sport,
    input  logic [15:0]                    dport,
    output logic [idx_width(N_PATH)-1:0]   idx
);
    localparam int PATH_W = idx_width(N_PATH);
    localparam int KEY_W  = 32;
    localparam int CHUNKS = (KEY_W + PATH_W - 1) / PATH_W;
    localparam int PAD_W  = CHUNKS * PATH_W;

    logic [PAD_W-1:0]  key;
    logic [PATH_W-1:0] fold;
    logic [PATH_W:0]   wide;

    always_comb begin
        key = '0;
        key[KEY_W-1:0] = {sport, dport};
        fold = '0;
        for (int c = 0; c < CHUNKS; c++) begin
            fold = fold ^ key[c*PATH_W +: PATH_W];
        end
        wide = {1'b0, fold} % (PATH_W+1)'(N_PATH);
        idx  = wide[PATH_W-1:0];
    end

endmodule

// File: rtl/lat_mpath_pick.sv
`timescale 1ns/1ps
// Lowest-latency live path of one destination row; ties go to lowest index.
module lat_mpath_pick
    import lat_mpath_pkg::*;
#(
    parameter int N_PATH = 2,
    parameter int LAT_W  = 16
) (
    input  logic [N_PATH*LAT_W-1:0]        lat_row,
    input  logic [N_PATH-1:0]              live_row,
    output logic [idx_width(N_PATH)-1:0]   best,
    output logic                           any_live
);
    localparam int PATH_W = idx_width(N_PATH);

    logic [LAT_W-1:0] best_lat;

    always_comb begin
        best     = '0;
        best_lat = '1;
        any_live = 1'b0;
        for (int p = 0; p < N_PATH; p++) begin
            if (live_row[p] && (!any_live || (lat_row[p*LAT_W +: LAT_W] < best_lat))) begin
                best     = PATH_W'(p);
                best_lat = lat_row[p*LAT_W +: LAT_W];
                any_live = 1'b1;
            end
        end
    end

endmodule

// File: rtl/lat_mpath_lfsr.sv
`timescale 1ns/1ps
// Free-running Galois LFSR; exposes a DRAW_W-bit random draw.
module lat_mpath_lfsr #(
    parameter int           W      = 16,
    parameter int           DRAW_W = 8,
    parameter logic [W-1:0] TAPS   = 16'hB400,
    parameter logic [W-1:0] SEED   = 16'hACE1
) (
    input  logic              clk,
    input  logic              rst,
    output logic [DRAW_W-1:0] draw
);
    logic [W-1:0] st_q;

    always_ff @(posedge clk) begin
        if (rst) st_q <= SEED;
        else     st_q <= {1'b0, st_q[W-1:1]} ^ (st_q[0] ? TAPS : '0);
    end

    assign draw = st_q[DRAW_W-1:0];

endmodule

// File: rtl/lat_mpath_sel.sv
`timescale 1ns/1ps
module lat_mpath_sel
    import lat_mpath_pkg::*;
#(
    parameter int N_DEST    = 4,
    parameter int N_PATH    = 2,
    parameter int TS_W      = 16,
    parameter int PROB_W    = 8,
    parameter int AGE_LIMIT = 200,
    parameter int LFSR_W    = 16,
    parameter logic [LFSR_W-1:0] LFSR_TAPS = 16'hB400,
    parameter logic [LFSR_W-1:0] LFSR_SEED = 16'hACE1,
    localparam int DEST_W   = idx_width(N_DEST),
    localparam int PATH_W   = idx_width(N_PATH),
    localparam int N_SLOT   = N_DEST * N_PATH,
    localparam int PORT_W   = idx_width(N_SLOT)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [PROB_W:0]   pref_level,
    input  logic              req_valid,
    input  logic [DEST_W-1:0] req_dest,
    input  logic [15:0]       req_sport,
    input  logic [15:0]       req_dport,
    input  logic              req_stamp,
    input  logic              ack_valid,
    input  logic [DEST_W-1:0] ack_dest,
    input  logic [PATH_W-1:0] ack_path,
    input  logic [TS_W-1:0]   ack_delay,
    output logic              sel_valid,
    output logic [PORT_W-1:0] sel_port,
    output logic [PATH_W-1:0] sel_path,
    output logic              sel_stamped,
    output logic [TS_W-1:0]   sel_ts
);
    logic [N_SLOT*TS_W-1:0]   lat_flat;
    logic [N_SLOT-1:0]        live_vec;
    logic [N_PATH*TS_W-1:0]   lat_row;
    logic [N_PATH-1:0]        live_row;
    logic [PATH_W-1:0]        hash_idx;
    logic [PATH_W-1:0]        best_idx;
    logic                     any_live;
    logic [PROB_W-1:0]        draw;
    logic                     take_best;
    logic [PATH_W-1:0]        pick;
    logic [PORT_W-1:0]        pick_port;
    logic [TS_W-1:0]          ts_q;

    // one tracker per destination/path slot
    for (genvar s = 0; s < N_SLOT; s++) begin : g_slot
        logic hit;
        assign hit = ack_valid
                   && (ack_dest == DEST_W'(s / N_PATH))
                   && (ack_path == PATH_W'(s % N_PATH));
        lat_mpath_track #(
            .LAT_W     (TS_W),
            .AGE_LIMIT (AGE_LIMIT)
        ) u_track (
            .clk     (clk),
            .rst     (rst),
            .upd     (hit),
            .upd_lat (ack_delay),
            .lat     (lat_flat[s*TS_W +: TS_W]),
            .live    (live_vec[s])
        );
    end

    assign lat_row  = lat_flat[int'(req_dest)*N_PATH*TS_W +: N_PATH*TS_W];
    assign live_row = live_vec[int'(req_dest)*N_PATH +: N_PATH];

    lat_mpath_hash #(.N_PATH(N_PATH)) u_hash (
        .sport (req_sport),
        .dport (req_dport),
        .idx   (hash_idx)
    );

    lat_mpath_pick #(.N_PATH(N_PATH), .LAT_W(TS_W)) u_pick (
        .lat_row  (lat_row),
        .live_row (live_row),
        .best     (best_idx),
        .any_live (any_live)
    );

    lat_mpath_lfsr #(
        .W      (LFSR_W),
        .DRAW_W (PROB_W),
        .TAPS   (LFSR_TAPS),
        .SEED   (LFSR_SEED)
    ) u_lfsr (
        .clk  (clk),
        .rst  (rst),
        .draw (draw)
    );

    // path decision
    always_comb begin
        take_best = ({1'b0, draw} < pref_level);
        if (!any_live)                         pick = hash_idx;
        else if (take_best || !live_row[hash_idx]) pick = best_idx;
        else                                   pick = hash_idx;
        pick_port = PORT_W'(int'(req_dest) * N_PATH + int'(pick));
    end

    // departure time base
    always_ff @(posedge clk) begin
        if (rst) ts_q <= '0;
        else     ts_q <= ts_q + 1'b1;
    end

    // registered result
    always_ff @(posedge clk) begin
        if (rst) begin
            sel_valid   <= 1'b0;
            sel_port    <= '0;
            sel_path    <= '0;
            sel_stamped <= 1'b0;
            sel_ts      <= '0;
        end else begin
            sel_valid <= req_valid;
            if (req_valid) begin
                sel_port    <= pick_port;
                sel_path    <= pick;
                sel_stamped <= req_stamp;
                sel_ts      <= req_stamp ? ts_q : '0;
            end
        end
    end

endmodule

// File: rtl/lat_mpath_sel_chk.sv
`timescale 1ns/1ps
module lat_mpath_sel_chk
    import lat_mpath_pkg::*;
#(
    parameter int N_DEST = 4,
    parameter int N_PATH = 2,
    parameter int TS_W   = 16,
    localparam int DEST_W = idx_width(N_DEST),
    localparam int PATH_W = idx_width(N_PATH),
    localparam int N_SLOT = N_DEST * N_PATH,
    localparam int PORT_W = idx_width(N_SLOT)
) (
    input logic              clk,
    input logic              rst,
    input logic              req_valid,
    input logic [DEST_W-1:0] req_dest,
    input logic              req_stamp,
    input logic              ack_valid,
    input logic [DEST_W-1:0] ack_dest,
    input logic [PATH_W-1:0] ack_path,
    input logic              sel_valid,
    input logic [PORT_W-1:0] sel_port,
    input logic [PATH_W-1:0] sel_path,
    input logic              sel_stamped,
    input logic [TS_W-1:0]   sel_ts,
    input logic [N_SLOT-1:0] live_vec
);
    logic [N_PATH-1:0] prev_row;

    always_ff @(posedge clk) begin
        prev_row <= live_vec[int'(req_dest)*N_PATH +: N_PATH];
    end

    AST_SEL_FOLLOWS_REQ: assert property (@(posedge clk) disable iff (rst)
        req_valid |=> sel_valid); // R1
    AST_SEL_NEEDS_REQ: assert property (@(posedge clk) disable iff (rst)
        !req_valid |=> !sel_valid); // R1
    AST_PORT_MAP: assert property (@(posedge clk) disable iff (rst)
        req_valid |=> (int'(sel_port) == int'($past(req_dest)) * N_PATH + int'(sel_path))); // R2
    AST_PICK_LIVE: assert property (@(posedge clk) disable iff (rst)
        req_valid |=> (!(|prev_row) || prev_row[sel_path])); // R7
    AST_ACK_REVIVES: assert property (@(posedge clk) disable iff (rst)
        (ack_valid && (int'(ack_path) < N_PATH)) |=> live_vec[int'($past(ack_dest)) * N_PATH + int'($past(ack_path))]); // R8
    AST_STAMP_FLAG: assert property (@(posedge clk) disable iff (rst)
        req_valid |=> (sel_stamped == $past(req_stamp))); // R10
    AST_UNSTAMPED_ZERO: assert property (@(posedge clk) disable iff (rst)
        (sel_valid && !sel_stamped) |-> (sel_ts == '0)); // R10
    AST_TS_STEP: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_stamp && sel_valid && sel_stamped) |=> (sel_ts == $past(sel_ts) + 1'b1)); // R10

endmodule

bind lat_mpath_sel lat_mpath_sel_chk #(
    .N_DEST (N_DEST),
    .N_PATH (N_PATH),
    .TS_W   (TS_W)
) u_chk (
    .clk         (clk),
    .rst         (rst),
    .req_valid   (req_valid),
    .req_dest    (req_dest),
    .req_stamp   (req_stamp),
    .ack_valid   (ack_valid),
    .ack_dest    (ack_dest),
    .ack_path    (ack_path),
    .sel_valid   (sel_valid),
    .sel_port    (sel_port),
    .sel_path    (sel_path),
    .sel_stamped (sel_stamped),
    .sel_ts      (sel_ts),
    .live_vec    (live_vec)
);

// File: tb/tb_lat_mpath_sel.sv
`timescale 1ns/1ps
module tb_lat_mpath_sel;
    localparam int L = 200;

    logic        clk = 1'b0;
    logic        rst;
    logic [8:0]  pref_level;
    logic        req_valid;
    logic [1:0]  req_dest;
    logic [15:0] req_sport;
    logic [15:0] req_dport;
    logic        req_stamp;
    logic        ack_valid;
    logic [1:0]  ack_dest;
    logic [0:0]  ack_path;
    logic [15:0] ack_delay;
    logic        sel_valid;
    logic [2:0]  sel_port;
    logic [0:0]  sel_path;
    logic        sel_stamped;
    logic [15:0] sel_ts;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;
    int last_ts;

    always #10 clk = ~clk;

    lat_mpath_sel #(.AGE_LIMIT(L)) dut (
        .clk(clk), .rst(rst), .pref_level(pref_level),
        .req_valid(req_valid), .req_dest(req_dest), .req_sport(req_sport),
        .req_dport(req_dport), .req_stamp(req_stamp),
        .ack_valid(ack_valid), .ack_dest(ack_dest), .ack_path(ack_path),
        .ack_delay(ack_delay),
        .sel_valid(sel_valid), .sel_port(sel_port), .sel_path(sel_path),
        .sel_stamped(sel_stamped), .sel_ts(sel_ts)
    );

    task automatic chk(input bit ok, input string tag, input int got, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s: got %0d expected %0d", tag, got, exp);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic send_ack(input int d, input int p, input int v);
        ack_valid = 1'b1; ack_dest = 2'(d); ack_path = 1'(p); ack_delay = 16'(v);
        @(negedge clk);
        ack_valid = 1'b0;
    endtask

    task automatic refresh_all(input int v);
        for (int d = 0; d < 4; d++)
            for (int p = 0; p < 2; p++)
                send_ack(d, p, v);
    endtask

    // request sampled at the next edge; result read one cycle later
    task automatic req_check(input int d, input int sp, input int dp, input bit stamp,
                             input int exp_path, input string tag);
        req_valid = 1'b1; req_dest = 2'(d); req_sport = 16'(sp); req_dport = 16'(dp);
        req_stamp = stamp;
        @(negedge clk);
        req_valid = 1'b0;
        chk(sel_valid == 1'b1, {tag, " valid (R1)"}, int'(sel_valid), 1);
        chk(int'(sel_path) == exp_path, {tag, " path"}, int'(sel_path), exp_path);
        chk(int'(sel_port) == d*2 + exp_path, {tag, " port (R2)"}, int'(sel_port), d*2 + exp_path);
        last_ts = int'(sel_ts);
    endtask

    task automatic t_reset();
        rst = 1'b1; pref_level = '0; req_valid = 0; req_dest = 0; req_sport = 0;
        req_dport = 0; req_stamp = 0; ack_valid = 0; ack_dest = 0; ack_path = 0; ack_delay = 0;
        idle(3);
        chk(sel_valid == 1'b0, "R1 reset sel_valid", int'(sel_valid), 0);
        rst = 1'b0;
        idle(1);
        chk(sel_valid == 1'b0, "R1 idle sel_valid", int'(sel_valid), 0);
    endtask

    task automatic t_init_state();
        pref_level = 9'd0;
        req_check(0, 1, 0, 0, 1, "R11 hash path live after reset");
        pref_level = 9'd256;
        req_check(0, 1, 0, 0, 0, "R11 equal zero latencies pick path 0");
    endtask

    task automatic t_hash();
        refresh_all(100);
        pref_level = 9'd0;
        req_check(0, 16'h0000, 16'h0000, 0, 0, "R3 parity 0");
        req_check(1, 16'h0001, 16'h0000, 0, 1, "R3 parity sport bit");
        req_check(2, 16'h0003, 16'h0100, 0, 1, "R3 three bits set");
        req_check(3, 16'hF0F0, 16'h0F0F, 0, 0, "R3 sixteen bits set");
        send_ack(1, 0, 5);
        req_check(1, 16'h8000, 16'h0000, 0, 1, "R4 pref 0 keeps live hash path");
    endtask

    task automatic t_best();
        refresh_all(100);
        send_ack(1, 0, 30);
        send_ack(1, 1, 20);
        pref_level = 9'd256;
        req_check(1, 0, 0, 0, 1, "R4 lowest latency path");
        send_ack(1, 1, 40);
        req_check(1, 0, 0, 0, 0, "R6 new latency used");
        send_ack(1, 1, 30);
        req_check(1, 1, 0, 0, 0, "R4 tie to lowest index");
    endtask

    task automatic t_same_cycle();
        send_ack(1, 0, 10);
        send_ack(1, 1, 20);
        pref_level = 9'd256;
        ack_valid = 1'b1; ack_dest = 2'd1; ack_path = 1'd0; ack_delay = 16'd90;
        req_check(1, 0, 0, 0, 0, "R6 same-cycle request sees old latency");
        ack_valid = 1'b0;
        req_check(1, 0, 0, 0, 1, "R6 following request sees new latency");
    endtask

    task automatic t_stamp();
        int t1;
        refresh_all(100);
        pref_level = 9'd0;
        req_check(0, 0, 0, 1, 0, "R10 stamped");
        chk(sel_stamped == 1'b1, "R10 stamp flag", int'(sel_stamped), 1);
        t1 = last_ts;
        idle(6);
        req_check(0, 0, 0, 1, 0, "R10 stamped later");
        chk(((last_ts - t1) & 16'hFFFF) == 7, "R10 timestamp delta", (last_ts - t1) & 16'hFFFF, 7);
        req_check(0, 0, 0, 0, 0, "R10 unstamped");
        chk(sel_stamped == 1'b0, "R10 no stamp flag", int'(sel_stamped), 0);
        chk(sel_ts == 16'd0, "R10 unstamped ts zero", int'(sel_ts), 0);
    endtask

    task automatic t_prob();
        int hits = 0;
        for (int b = 0; b < 4; b++) begin
            send_ack(3, 0, 10);
            send_ack(3, 1, 200);
            pref_level = 9'd128;
            req_valid = 1'b1; req_dest = 2'd3; req_sport = 16'd1; req_dport = 16'd0; req_stamp = 0;
            for (int i = 0; i < 60; i++) begin
                @(negedge clk);
                if (sel_valid && sel_path == 1'b0) hits++;
            end
            req_valid = 1'b0;
            idle(1);
        end
        chk(hits >= 72 && hits <= 168, "R5 preference share of 240", hits, 120);
    endtask

    task automatic t_timeout_edge();
        refresh_all(100);
        pref_level = 9'd0;
        send_ack(2, 0, 50);        // edge e
        send_ack(2, 1, 60);        // edge e+1
        idle(L - 1);
        req_check(2, 0, 0, 0, 0, "R7 still live at e+L+1");
        req_check(2, 0, 0, 0, 1, "R7 failed hash path skipped at e+L+2");
    endtask

    task automatic t_revive();
        pref_level = 9'd0;
        send_ack(0, 0, 50);        // edge e
        send_ack(0, 1, 60);        // edge e+1
        idle(L - 1);
        send_ack(0, 0, 50);        // sampled at expiry edge e+L+1
        req_check(0, 0, 0, 0, 0, "R8 ack wins over expiry");
        for (int i = 0; i < L + 5; i++) send_ack(0, 1, 60);
        req_check(0, 0, 0, 0, 1, "R7 expired path excluded");
        send_ack(0, 0, 70);
        req_check(0, 0, 0, 0, 0, "R8 ack revives failed path");
    endtask

    task automatic t_all_failed();
        idle(L + 5);
        pref_level = 9'd256;
        req_check(3, 1, 0, 0, 1, "R9 all failed uses hash 1");
        req_check(3, 0, 0, 0, 0, "R9 all failed uses hash 0");
    endtask

    initial begin
        t_reset();
        t_init_state();
        t_hash();
        t_best();
        t_same_cycle();
        t_stamp();
        t_prob();
        t_timeout_edge();
        t_revive();
        t_all_failed();
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: got 0 expected 1 (run did not finish)");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule